// File: doc/BRIEF.md
# Gated Period Timer

This block is a 32-bit up-counter that runs against a programmable period and drives one output pin. It advances either on every system clock (internal source), on every clock while a gate window opened by the external input is active, or once per synchronised rising edge of the external input (external source). A 2-bit enable mode selects off, one-shot, continuous, or continuous with the period taken from a reload register each time the counter wraps.

Software programs three write-only registers through a simple write port. The output pin shows a status bit that is either a pulse of 1 to 4 timer ticks starting at each period match, or a level that toggles each time the counter wraps to zero, giving a 50% duty-cycle clock. A one-cycle strobe marks every period match. The counter, period and status are brought out so the surrounding logic can observe them.

Top module: `gate_period_timer`

## Requirements
- R1: After reset the count, period, reload, status, output pin and match strobe are all 0, and the control register is 0 (mode off).
- R2: With mode 0 (control bits [1:0] = 0) the count holds its value on every cycle.
- R3: With mode 1 the count advances one per tick until it equals the period, then stays at the period; the match strobe fires exactly once.
- R4: With mode 2 the count advances until it equals the period and returns to 0 on the next tick, repeating forever; a period of 0 never matches.
- R5: With mode 3 the count behaves as in mode 2, and at each wrap to 0 the period register takes the reload register value (address 2); a period write on the same cycle takes priority.
- R6: A control write (address 0) that sets a nonzero mode while the current mode is 0 clears the count to 0 on that cycle; writing mode 0 then mode 1 re-arms a finished one-shot.
- R7: With control bit 2 = 1 the count ticks once per rising edge of the two-flop synchronised input; with control bit 4 = 1 the input is inverted first, so falling pin edges tick.
- R8: With control bit 2 = 0 and bit 3 = 1, the internal tick runs only between a synchronised rising edge of the input and the following falling edge; with bit 3 = 0 it ticks every cycle.
- R9: With control bit 6 = 0 (pulse mode) the status bit rises on a period match and stays high for W+1 ticks, where W is control bits [8:7].
- R10: With control bit 6 = 1 (clock mode) the status bit toggles at each wrap of the count to 0.
- R11: The output pin equals the status bit XOR control bit 5.
- R12: The match strobe is high for one system clock, in the cycle the count first shows the period value; period is written at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 reload |
| wr_data | input | 32 | Write data |
| ext_in | input | 1 | Asynchronous external input pin |
| tmr_out | output | 1 | Timer output pin |
| match_irq | output | 1 | One-cycle period-match strobe |
| status_o | output | 1 | Status bit |
| count_o | output | 32 | Current count |
| period_o | output | 32 | Current period register |

## Verification
On every cycle the assertions check that mode 0 freezes the count, that a finished one-shot stays at its period, that the match strobe never lasts two cycles and coincides with the count equal to the period, that a clock-mode toggle only happens as the count lands on zero, and that a pulse-mode rise of the status bit comes with a match. Only the bench scenarios can show the pulse width for each width code, the exact gate window and edge counts through the synchroniser, the period reload sequence, and the clearing and re-arming on mode writes, which it compares cycle by cycle against a reference model under random register writes and input toggles.

// File: rtl/gpt_pkg.sv
// Package: shared control layout and register addresses of the gated period timer.
// Assumes the control word occupies the low 9 bits of a write.
package gpt_pkg;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;

    typedef enum logic [1:0] {
        M_OFF    = 2'd0,
        M_ONCE   = 2'd1,
        M_CONT   = 2'd2,
        M_RELOAD = 2'd3
    } gpt_mode_e;

    // Packed MSB first: pwid [8:7], clk_mode [6], inv_out [5], inv_in [4],
    // gate_en [3], src_ext [2], mode [1:0].
    typedef struct packed {
        logic [1:0] pwid;
        logic       clk_mode;
        logic       inv_out;
        logic       inv_in;
        logic       gate_en;
        logic       src_ext;
        gpt_mode_e  mode;
    } gpt_ctrl_t;

    localparam int CTRL_W = $bits(gpt_ctrl_t);

endpackage

// File: rtl/gpt_regs.sv
// Module: register bank holding control, period and reload values.
// Assumes a write strobe of one cycle; a period write wins over a reload load.
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              load_reload,
    output gpt_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  period,
    output logic              arm
);

    logic [CNT_W-1:0] reload_q;
    logic             wr_ctrl;
    gpt_ctrl_t        new_ctrl;

    // Decode the control write and detect a start from the off mode.
    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        new_ctrl = gpt_ctrl_t'(wr_data[CTRL_W-1:0]);
        arm      = wr_ctrl && (ctrl.mode == M_OFF) && (new_ctrl.mode != M_OFF);
    end

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= new_ctrl;
    end

    // Hold the period, written directly or loaded from reload at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  period <= '0;
        else if (wr_en && (wr_addr == A_PERIOD))     period <= wr_data;
        else if (load_reload)                        period <= reload_q;
    end

    // Hold the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)                              reload_q <= '0;
        else if (wr_en && (wr_addr == A_RELOAD)) reload_q <= wr_data;
    end

endmodule

// File: rtl/gpt_tick.sv
// Module: builds the per-cycle count enable from the selected source.
// Assumes ext_in is asynchronous; it passes a SYNC_STAGES-flop synchroniser.
module gpt_tick
    import gpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ext_in,
    input  gpt_ctrl_t ctrl,
    output logic      tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   raw_prev;
    logic                   lvl_prev;
    logic                   gate_open;
    logic                   lvl;

    // Synchronise the external pin.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign lvl   = pin_s ^ ctrl.inv_in;

    // Remember last raw and polarity-adjusted levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_prev <= 1'b0;
            lvl_prev <= 1'b0;
        end else begin
            raw_prev <= pin_s;
            lvl_prev <= lvl;
        end
    end

    // Open the gate on a raw rising edge, close it on a raw falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gate_open <= 1'b0;
        else if (pin_s && !raw_prev)  gate_open <= 1'b1;
        else if (!pin_s && raw_prev)  gate_open <= 1'b0;
    end

    // Select the count enable for this cycle.
    always_comb begin
        if (ctrl.mode == M_OFF)  tick = 1'b0;
        else if (ctrl.src_ext)   tick = lvl && !lvl_prev;
        else if (ctrl.gate_en)   tick = gate_open;
        else                     tick = 1'b1;
    end

endmodule

// File: rtl/gpt_count.sv
// Module: the up-counter with match, wrap and the registered match strobe.
// Assumes arm has priority over a tick in the same cycle.
module gpt_count
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  gpt_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             hit,
    output logic             wrap,
    output logic             irq
);

    logic [CNT_W-1:0] next_up;
    logic             at_per;
    logic             cont;

    // Classify the current tick as a match, a wrap or neither.
    always_comb begin
        next_up = count + 1'b1;
        at_per  = (count == period);
        cont    = (mode == M_CONT) || (mode == M_RELOAD);
        hit     = tick && !arm && !at_per && (next_up == period);
        wrap    = tick && !arm && at_per && cont;
    end

    // Advance, wrap or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (arm)            count <= '0;
        else if (wrap)           count <= '0;
        else if (tick && !at_per) count <= next_up;
    end

    // Register the match strobe so it lines up with the count.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit;
    end

endmodule

// File: rtl/gpt_outgen.sv
// Module: produces the status bit in pulse or clock mode and the output pin.
// Assumes pulse length is counted in ticks and a new match restarts a pulse.
module gpt_outgen #(
    parameter int PW_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            hit,
    input  logic            wrap,
    input  logic            clk_mode,
    input  logic [PW_W-1:0] pwid,
    input  logic            inv_out,
    output logic            status,
    output logic            pin
);

    logic [PW_W-1:0] remain;

    // Update the status bit and the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
            remain <= '0;
        end else if (clk_mode) begin
            if (wrap) status <= !status;
        end else if (hit) begin
            status <= 1'b1;
            remain <= pwid;
        end else if (tick && status) begin
            if (remain == '0) status <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // Apply the output polarity.
    assign pin = status ^ inv_out;

endmodule

// File: rtl/gate_period_timer.sv
// Module: top of the gated period timer; wires registers, tick, counter, output.
// Assumes one system clock and synchronous active-low reset throughout.
module gate_period_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PW_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_in,
    output logic              tmr_out,
    output logic              match_irq,
    output logic              status_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  period_o
);

    gpt_ctrl_t  ctrl;
    logic       arm;
    logic       tick;
    logic       hit;
    logic       wrap;
    logic       load_reload;
    logic [1:0] mode_bits;
    logic       clk_mode;

    assign load_reload = wrap && (ctrl.mode == M_RELOAD);
    assign mode_bits   = ctrl.mode;
    assign clk_mode    = ctrl.clk_mode;

    gpt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_reload(load_reload), .ctrl(ctrl),
        .period(period_o), .arm(arm)
    );

    gpt_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .ctrl(ctrl), .tick(tick)
    );

    gpt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .mode(ctrl.mode),
        .period(period_o), .count(count_o), .hit(hit), .wrap(wrap),
        .irq(match_irq)
    );

    gpt_outgen #(.PW_W(PW_W)) u_out (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .wrap(wrap),
        .clk_mode(ctrl.clk_mode), .pwid(ctrl.pwid[PW_W-1:0]),
        .inv_out(ctrl.inv_out), .status(status_o), .pin(tmr_out)
    );

endmodule

// File: rtl/gpt_checker.sv
// Module: temporal checks on the timer, attached by bind.
// Assumes it sees the top's ports plus the decoded mode and clock-mode bits.
module gpt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       mode_bits,
    input logic             clk_mode,
    input logic             match_irq,
    input logic             status_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] period_o
);

    // R2: mode 0 without a write freezes the count.
    a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'd0 && !wr_en) |=> $stable(count_o));

    // R3: a finished one-shot stays at its period.
    a_r3_once_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 2'd1 && count_o == period_o && !wr_en) |=> $stable(count_o));

    // R12: the match strobe never lasts two cycles.
    a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

    // R12: the match strobe coincides with the count at the period.
    a_r12_irq_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        (match_irq && !$past(wr_en)) |-> (count_o == period_o));

    // R10: in clock mode the status only changes as the count lands on zero.
    a_r10_toggle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_mode) && (status_o != $past(status_o))) |-> (count_o == '0));

    // R9: in pulse mode a rising status comes with a match.
    a_r9_pulse_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clk_mode) && $rose(status_o)) |-> match_irq);

endmodule

bind gate_period_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_bits(mode_bits),
    .clk_mode(clk_mode), .match_irq(match_irq), .status_o(status_o),
    .count_o(count_o), .period_o(period_o)
);

// File: tb/gate_period_timer_tb.sv
module gate_period_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        ext_in = 1'b0;
    logic        tmr_out, match_irq, status_o;
    logic [31:0] count_o, period_o;

    int n_chk = 0;
    int n_bad = 0;
    int n_irq = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gate_period_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_in(ext_in), .tmr_out(tmr_out),
        .match_irq(match_irq), .status_o(status_o), .count_o(count_o),
        .period_o(period_o)
    );

    // Reference model state, built from the requirements.
    logic        m_s1, m_s2, m_rawp, m_lvlp, m_gate;
    logic [8:0]  m_ctl;
    logic [31:0] m_cnt, m_per, m_rel;
    logic        m_st, m_irq;
    logic [1:0]  m_rem;

    function automatic logic f_tick(input logic [8:0] c, input logic s2,
                                    input logic lvlp, input logic g);
        if (c[1:0] == 2'd0) return 1'b0;
        if (c[2])           return (s2 ^ c[4]) & ~lvlp;
        if (c[3])           return g;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        logic t, arm, hit, wrap;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_rawp <= 0; m_lvlp <= 0; m_gate <= 0;
            m_ctl <= '0; m_cnt <= '0; m_per <= '0; m_rel <= '0;
            m_st <= 0; m_irq <= 0; m_rem <= '0;
        end else begin
            t    = f_tick(m_ctl, m_s2, m_lvlp, m_gate);
            arm  = wr_en && wr_addr == 2'd0 && m_ctl[1:0] == 2'd0 && wr_data[1:0] != 2'd0;
            hit  = t && !arm && m_cnt != m_per && (m_cnt + 32'd1) == m_per;
            wrap = t && !arm && m_cnt == m_per && m_ctl[1];
            m_s1 <= ext_in; m_s2 <= m_s1; m_rawp <= m_s2; m_lvlp <= m_s2 ^ m_ctl[4];
            if (m_s2 && !m_rawp) m_gate <= 1;
            else if (!m_s2 && m_rawp) m_gate <= 0;
            if (wr_en && wr_addr == 2'd0) m_ctl <= wr_data[8:0];
            if (wr_en && wr_addr == 2'd2) m_rel <= wr_data;
            if (wr_en && wr_addr == 2'd1) m_per <= wr_data;
            else if (wrap && m_ctl[1:0] == 2'd3) m_per <= m_rel;
            if (arm || wrap) m_cnt <= '0;
            else if (t && m_cnt != m_per) m_cnt <= m_cnt + 32'd1;
            m_irq <= hit;
            if (m_ctl[6]) begin
                if (wrap) m_st <= !m_st;
            end else if (hit) begin
                m_st <= 1; m_rem <= m_ctl[8:7];
            end else if (t && m_st) begin
                if (m_rem == 2'd0) m_st <= 0; else m_rem <= m_rem - 2'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Advance n cycles, comparing all outputs with the model at each negedge.
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (match_irq) n_irq++;
            chk("R4 count vs model", count_o, m_cnt);
            chk("R5 period vs model", period_o, m_per);
            chk("R9 status vs model", {31'd0, status_o}, {31'd0, m_st});
            chk("R11 pin vs model", {31'd0, tmr_out}, {31'd0, m_st ^ m_ctl[5]});
            chk("R12 strobe vs model", {31'd0, match_irq}, {31'd0, m_irq});
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 0;
    endtask

    initial begin
        logic [31:0] v;
        int run, best, tog;
        logic prev;
        void'($urandom(32'h1d2c));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 period", period_o, 0);
        chk("R1 status", {31'd0, status_o}, 0);
        chk("R1 pin", {31'd0, tmr_out}, 0);
        chk("R1 strobe", {31'd0, match_irq}, 0);

        // R3 one-shot to period 5
        wr(2'd1, 32'd5);
        n_irq = 0;
        wr(2'd0, 32'h001);
        cyc(20);
        chk("R3 parked at period", count_o, 5);
        chk("R3 single match", n_irq, 1);
        // R2 mode 0 holds
        wr(2'd0, 32'h000);
        cyc(10);
        chk("R2 held", count_o, 5);
        // R6 re-arm clears count
        wr(2'd0, 32'h001);
        chk("R6 cleared on arm", count_o, 0);
        cyc(10);
        chk("R6 re-armed one-shot", count_o, 5);

        // R4 continuous, period 3
        wr(2'd0, 32'h000);
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h002);
        best = 0; n_irq = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            if (count_o > best) best = count_o;
        end
        chk("R4 max count", best, 3);
        chk("R4 matches in 40 cycles", n_irq, 10);

        // R5 reload mode
        wr(2'd0, 32'h000);
        wr(2'd2, 32'd6);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h003);
        cyc(30);
        chk("R5 period reloaded", period_o, 6);

        // R9 pulse width 4 ticks (pwid 3)
        wr(2'd0, 32'h000);
        wr(2'd1, 32'd9);
        wr(2'd0, 32'h182);
        run = 0; best = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            if (status_o) run++; else run = 0;
            if (run > best) best = run;
        end
        chk("R9 pulse width", best, 4);
        // R11 inverted output
        wr(2'd0, 32'h000);
        wr(2'd0, 32'h1A2);
        cyc(3);
        chk("R11 pin inverted", {31'd0, tmr_out}, {31'd0, ~status_o});

        // R10 clock mode, period 1
        wr(2'd0, 32'h000);
        wr(2'd1, 32'd1);
        wr(2'd0, 32'h042);
        tog = 0; prev = status_o;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (status_o != prev) tog++;
            prev = status_o;
        end
        chk("R10 toggles in 20 cycles", {31'd0, tog >= 9}, 1);

        // R7 external rising edges
        wr(2'd0, 32'h000);
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h006);
        for (int i = 0; i < 5; i++) begin
            ext_in = 1; cyc(4); ext_in = 0; cyc(4);
        end
        chk("R7 five rising edges", count_o, 5);
        wr(2'd0, 32'h000);
        ext_in = 1; cyc(5);
        wr(2'd0, 32'h016);
        for (int i = 0; i < 3; i++) begin
            ext_in = 0; cyc(4); ext_in = 1; cyc(4);
        end
        chk("R7 inverted counts falls", count_o, 3);

        // R8 gated internal source
        wr(2'd0, 32'h000);
        ext_in = 0; cyc(5);
        wr(2'd1, 32'd1000);
        wr(2'd0, 32'h00A);
        cyc(10);
        chk("R8 gate closed", count_o, 0);
        ext_in = 1; cyc(20);
        ext_in = 0; cyc(10);
        v = count_o;
        chk("R8 window length", v, 20);
        cyc(10);
        chk("R8 closed again", count_o, v);

        // Random mix against the model
        wr(2'd0, 32'h000);
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom % 8) == 0;
            wr_addr = 2'($urandom % 3);
            wr_data = (wr_addr == 2'd0) ? {23'd0, 9'($urandom)} : 32'($urandom % 8);
            if (($urandom % 3) == 0) ext_in = ~ext_in;
            cyc(1);
        end
        wr_en = 0;
        cyc(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule